// File: doc/BRIEF.md
# Writeback Pixel Format Packer

This block sits between a compositor's pixel stream and a memory word assembler. Each input beat carries one pixel with four 8-bit channels: red, green, blue and alpha. The block repacks it into one of twelve stored layouts chosen by a 4-bit format code. The layouts differ in channel order and channel depth: 32-bit with alpha, 24-bit without alpha, 16-bit 5/6/5, and 16-bit 4/4/4/4. The alpha field is handled in one of two ways. It can be stored, optionally inverted. Otherwise it is replaced by a constant fill chosen by the invert control. A 4-bit store mask switches off individual byte positions within each 4-byte group of the output stream.

Each output beat carries one packed pixel in little-endian lane order. Lane 0 holds the least significant byte. It comes with a keep vector giving the pixel's byte count and a write mask that the assembler applies when it merges the bytes into memory words. The block tracks the running byte position modulo 4 so that the store mask lines up with the memory groups. A start-of-frame marker on a pixel resets that position to zero.

Both data sides use valid/ready. An input pixel is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An output beat is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output stays frozen. The configuration pins are plain levels that are sampled together with each accepted pixel.

Top module: `wb_pixel_packer`

## Requirements
- R1: A pixel accepted at a clock edge appears on the output after that edge, so `out_valid` is high in the following cycle. `in_ready` equals `!out_valid || out_ready`.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_keep` and `out_wmask` hold their values.
- R3: `out_keep` is 4'b0011 for codes 0-3, 6 and 7, 4'b0111 for codes 8 and 9, and 4'b1111 for codes 12-15 and for reserved codes. Bytes are packed little-endian from lane 0.
- R4: 32-bit codes, channels named from byte 3 down to byte 0: 12 = A,B,G,R; 13 = A,R,G,B; 14 = B,G,R,A; 15 = R,G,B,A.
- R5: 24-bit codes: 8 puts B in byte 2, G in byte 1 and R in byte 0. 9 puts R in byte 2, G in byte 1 and B in byte 0. Alpha is not stored.
- R6: 16-bit 5/6/5 codes keep the top 5, 6 and 5 bits of the channels. Code 6 = B[15:11], G[10:5], R[4:0]. Code 7 = R[15:11], G[10:5], B[4:0].
- R7: 16-bit 4/4/4/4 codes keep the top 4 bits of each channel. The nibbles are ordered from bits 15:12 down to 3:0 as follows: 0 = A,B,G,R; 1 = A,R,G,B; 2 = B,G,R,A; 3 = R,G,B,A.
- R8: With alpha store enabled, the alpha field holds the input alpha, bitwise inverted when the invert control is set.
- R9: With alpha store disabled, the alpha field is all ones when the invert control is set and all zeros when it is clear.
- R10: Reserved codes 4, 5, 10 and 11 produce a 4-byte pixel whose data is all zeros.
- R11: `out_wmask[i]` is `out_keep[i] & byte_en[(p+i) mod 4]`, where p is the stream byte position of the pixel. p is 0 for a pixel flagged start-of-frame and for the first pixel after reset. Otherwise p is the previous pixel's p plus its byte count, modulo 4.
- R12: During reset and right after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fmt | input | 4 | Stored format code |
| cfg_alpha_en | input | 1 | Store the alpha channel instead of a fill |
| cfg_alpha_inv | input | 1 | Invert the stored alpha, or select the all-ones fill |
| cfg_byte_en | input | 4 | Store enable for each byte position within a 4-byte group |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel can be accepted |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| in_a | input | 8 | Alpha channel |
| out_valid | output | 1 | Packed beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 32 | Packed pixel bytes, lane 0 first |
| out_keep | output | 4 | Lanes holding pixel bytes |
| out_wmask | output | 4 | Lanes to be written to memory |

## Verification
On every cycle, the assertions check that a stalled beat stays frozen, that an accepted pixel is always followed by a valid beat, that the keep vector is one of the three legal shapes, and that the write mask never reaches outside the kept lanes. Which bytes end up in which lane, the truncation of channels, the alpha store and fill rules, the zeroing for reserved codes, and the running alignment of the store mask across 2-, 3- and 4-byte pixels can only be shown by the bench's scenarios. The bench compares every beat against its reference model while the output back-pressure is both steady and irregular.

// File: rtl/wbpk_pkg.sv
package wbpk_pkg;

  localparam int CHAN_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = CHAN_W * LANES;
  localparam int CNT_W  = $clog2(LANES) + 1;

  typedef enum logic [2:0] {
    LAY_4444 = 3'd0,
    LAY_565  = 3'd1,
    LAY_888  = 3'd2,
    LAY_8888 = 3'd3,
    LAY_RSVD = 3'd4
  } layout_e;

  typedef struct packed {
    layout_e          layout;
    logic             red_high;   // red sits above blue
    logic             alpha_low;  // alpha in the lowest field
    logic [CNT_W-1:0] nbytes;
  } fmt_info_t;

endpackage

// File: rtl/wbpk_fmt_decode.sv
module wbpk_fmt_decode
  import wbpk_pkg::*;
(
  input  logic [3:0] code,
  output fmt_info_t  info
);

  always_comb begin
    info.red_high  = code[0];
    info.alpha_low = code[1];
    unique case (code[3:2])
      2'b00: info.layout = LAY_4444;
      2'b01: info.layout = code[1] ? LAY_565 : LAY_RSVD;
      2'b10: info.layout = code[1] ? LAY_RSVD : LAY_888;
      default: info.layout = LAY_8888;
    endcase
    unique case (info.layout)
      LAY_4444, LAY_565: info.nbytes = CNT_W'(2);
      LAY_888:           info.nbytes = CNT_W'(3);
      default:           info.nbytes = CNT_W'(4);
    endcase
  end

endmodule

// File: rtl/wbpk_chan_pack.sv
module wbpk_chan_pack
  import wbpk_pkg::*;
(
  input  fmt_info_t         info,
  input  logic [CHAN_W-1:0] r,
  input  logic [CHAN_W-1:0] g,
  input  logic [CHAN_W-1:0] b,
  input  logic [CHAN_W-1:0] a,
  input  logic              alpha_en,
  input  logic              alpha_inv,
  output logic [WORD_W-1:0] word,
  output logic [LANES-1:0]  keep
);

  localparam int N4  = CHAN_W / 2;
  localparam int N5  = CHAN_W - 3;
  localparam int N6  = CHAN_W - 2;
  localparam int H16 = 2 * CHAN_W;
  localparam int H24 = 3 * CHAN_W;

  logic [CHAN_W-1:0] av, hi, lo;

  always_comb begin
    if (alpha_en) av = a ^ {CHAN_W{alpha_inv}};
    else          av = {CHAN_W{alpha_inv}};
    hi = info.red_high ? r : b;
    lo = info.red_high ? b : r;
  end

  always_comb begin
    word = '0;
    unique case (info.layout)
      LAY_8888:
        word = info.alpha_low ? {hi, g, lo, av} : {av, hi, g, lo};
      LAY_888:
        word = {{(WORD_W-H24){1'b0}}, hi, g, lo};
      LAY_565:
        word = {{(WORD_W-H16){1'b0}},
                hi[CHAN_W-1 -: N5], g[CHAN_W-1 -: N6], lo[CHAN_W-1 -: N5]};
      LAY_4444:
        word = info.alpha_low
             ? {{(WORD_W-H16){1'b0}}, hi[CHAN_W-1 -: N4], g[CHAN_W-1 -: N4],
                lo[CHAN_W-1 -: N4], av[CHAN_W-1 -: N4]}
             : {{(WORD_W-H16){1'b0}}, av[CHAN_W-1 -: N4], hi[CHAN_W-1 -: N4],
                g[CHAN_W-1 -: N4], lo[CHAN_W-1 -: N4]};
      default: word = '0;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign keep[i] = (CNT_W'(i) < info.nbytes);
  end

endmodule

// File: rtl/wbpk_lane_gate.sv
module wbpk_lane_gate
  import wbpk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             sof,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [LANES-1:0] keep,
  input  logic [LANES-1:0] byte_en,
  output logic [LANES-1:0] wmask
);

  localparam int OFF_W = $clog2(LANES);

  logic [OFF_W-1:0] off_q, base;

  assign base = sof ? '0 : off_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OFF_W-1:0] pos;
    assign pos      = base + OFF_W'(i);
    assign wmask[i] = keep[i] & byte_en[pos];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       off_q <= '0;
    else if (advance) off_q <= base + nbytes[OFF_W-1:0];
  end

endmodule

// File: rtl/wbpk_out_stage.sv
module wbpk_out_stage
  import wbpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [LANES-1:0]  in_keep,
  input  logic [LANES-1:0]  in_wmask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [LANES-1:0]  out_keep,
  output logic [LANES-1:0]  out_wmask
);

  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_keep  <= '0;
      out_wmask <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= in_word;
      out_keep  <= in_keep;
      out_wmask <= in_wmask;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) &&
    $stable(out_keep) && $stable(out_wmask)); // R2

  AST_ACCEPT_GIVES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1

  AST_KEEP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_keep == 4'b0011 || out_keep == 4'b0111 ||
                   out_keep == 4'b1111)); // R3

endmodule

// File: rtl/wb_pixel_packer.sv
module wb_pixel_packer
  import wbpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_fmt,
  input  logic              cfg_alpha_en,
  input  logic              cfg_alpha_inv,
  input  logic [LANES-1:0]  cfg_byte_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic [CHAN_W-1:0] in_r,
  input  logic [CHAN_W-1:0] in_g,
  input  logic [CHAN_W-1:0] in_b,
  input  logic [CHAN_W-1:0] in_a,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [LANES-1:0]  out_keep,
  output logic [LANES-1:0]  out_wmask
);

  fmt_info_t         info;
  logic [WORD_W-1:0] word;
  logic [LANES-1:0]  keep, wmask;
  logic              accept;

  assign accept = in_valid && in_ready;

  wbpk_fmt_decode u_dec (
    .code (cfg_fmt),
    .info (info)
  );

  wbpk_chan_pack u_pack (
    .info      (info),
    .r         (in_r),
    .g         (in_g),
    .b         (in_b),
    .a         (in_a),
    .alpha_en  (cfg_alpha_en),
    .alpha_inv (cfg_alpha_inv),
    .word      (word),
    .keep      (keep)
  );

  wbpk_lane_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (accept),
    .sof     (in_sof),
    .nbytes  (info.nbytes),
    .keep    (keep),
    .byte_en (cfg_byte_en),
    .wmask   (wmask)
  );

  wbpk_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (word),
    .in_keep   (keep),
    .in_wmask  (wmask),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_data),
    .out_keep  (out_keep),
    .out_wmask (out_wmask)
  );

  AST_MASK_WITHIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_wmask & ~out_keep) == '0)); // R11

endmodule

// File: tb/wb_pixel_packer_test.sv
module wb_pixel_packer_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic [3:0]  cfg_fmt;
  logic        cfg_alpha_en, cfg_alpha_inv;
  logic [3:0]  cfg_byte_en;
  logic        in_valid, in_ready, in_sof;
  logic [7:0]  in_r, in_g, in_b, in_a;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  logic [3:0]  out_keep, out_wmask;

  wb_pixel_packer uut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_alpha_en(cfg_alpha_en),
    .cfg_alpha_inv(cfg_alpha_inv), .cfg_byte_en(cfg_byte_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_a(in_a),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_keep(out_keep), .out_wmask(out_wmask)
  );

  typedef struct {
    logic [31:0] d;
    logic [3:0]  k;
    logic [3:0]  m;
    int          code;
    bit          ae;
  } beat_t;

  beat_t       q[$];
  int          ref_off = 0;
  int          checks = 0, fails = 0;
  bit          done = 0, stall_mode = 0;
  bit          prev_stall = 0;
  logic [31:0] prev_d;
  logic [3:0]  prev_k, prev_m;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic int nbytes_of(input int code);
    if (code <= 3 || code == 6 || code == 7) return 2;
    if (code == 8 || code == 9) return 3;
    return 4;
  endfunction

  function automatic logic [31:0] expect_word(input int code, input int r,
      input int g, input int b, input int a, input bit ae, input bit ai);
    int av;
    av = ae ? (ai ? 255 - a : a) : (ai ? 255 : 0);
    case (code)
      0:  return ((av>>4)<<12) | ((b>>4)<<8) | ((g>>4)<<4) | (r>>4);
      1:  return ((av>>4)<<12) | ((r>>4)<<8) | ((g>>4)<<4) | (b>>4);
      2:  return ((b>>4)<<12) | ((g>>4)<<8) | ((r>>4)<<4) | (av>>4);
      3:  return ((r>>4)<<12) | ((g>>4)<<8) | ((b>>4)<<4) | (av>>4);
      6:  return ((b>>3)<<11) | ((g>>2)<<5) | (r>>3);
      7:  return ((r>>3)<<11) | ((g>>2)<<5) | (b>>3);
      8:  return (b<<16) | (g<<8) | r;
      9:  return (r<<16) | (g<<8) | b;
      12: return (av<<24) | (b<<16) | (g<<8) | r;
      13: return (av<<24) | (r<<16) | (g<<8) | b;
      14: return (b<<24) | (g<<16) | (r<<8) | av;
      15: return (r<<24) | (g<<16) | (b<<8) | av;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string fmt_tag(input int code, input bit ae);
    string t;
    if (code <= 3) t = "R7";
    else if (code == 6 || code == 7) t = "R6";
    else if (code == 8 || code == 9) t = "R5";
    else if (code >= 12) t = "R4";
    else t = "R10";
    if (code <= 3 || code >= 12) t = {t, ae ? " R8" : " R9"};
    return t;
  endfunction

  // reference model, compared every cycle at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid == (q.size() != 0), "R1 out_valid",
          32'(out_valid), 32'(q.size() != 0));
      chk(in_ready == (!out_valid || out_ready), "R1 in_ready",
          32'(in_ready), 32'(!out_valid || out_ready));
      if (prev_stall)
        chk(out_valid && out_data == prev_d && out_keep == prev_k &&
            out_wmask == prev_m, "R2 stall hold", out_data, prev_d);
      if (out_valid && out_ready && q.size() != 0) begin
        beat_t e;
        e = q.pop_front();
        chk(out_keep == e.k, "R3 keep", 32'(out_keep), 32'(e.k));
        chk(out_data == e.d, {fmt_tag(e.code, e.ae), " data"}, out_data, e.d);
        chk(out_wmask == e.m, "R11 wmask", 32'(out_wmask), 32'(e.m));
      end
      prev_stall = out_valid && !out_ready;
      prev_d = out_data; prev_k = out_keep; prev_m = out_wmask;
      if (in_valid && in_ready) begin
        beat_t e;
        int n;
        n = nbytes_of(int'(cfg_fmt));
        if (in_sof) ref_off = 0;
        e.code = int'(cfg_fmt);
        e.ae   = cfg_alpha_en;
        e.d    = expect_word(e.code, int'(in_r), int'(in_g), int'(in_b),
                             int'(in_a), cfg_alpha_en, cfg_alpha_inv);
        e.k = '0;
        e.m = '0;
        for (int i = 0; i < 4; i++) begin
          if (i < n) begin
            e.k[i] = 1'b1;
            e.m[i] = cfg_byte_en[(ref_off + i) % 4];
          end
        end
        ref_off = (ref_off + n) % 4;
        q.push_back(e);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic send(input int code, input bit ae, input bit ai,
                      input logic [3:0] be, input bit sof);
    bit fire;
    cfg_fmt = 4'(code); cfg_alpha_en = ae; cfg_alpha_inv = ai;
    cfg_byte_en = be; in_sof = sof;
    in_r = 8'($urandom); in_g = 8'($urandom);
    in_b = 8'($urandom); in_a = 8'($urandom);
    in_valid = 1'b1;
    do begin
      @(negedge clk);
      fire = in_ready;
      @(posedge clk);
      #1;
    end while (!fire);
    in_valid = 1'b0;
    in_sof = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; out_ready = 1'b1;
    cfg_fmt = '0; cfg_alpha_en = 0; cfg_alpha_inv = 0; cfg_byte_en = 4'hF;
    in_r = '0; in_g = '0; in_b = '0; in_a = '0;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R12 reset out_valid", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R12 reset in_ready", 32'(in_ready), 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 after reset out_valid", 32'(out_valid), 0);

    // first pixel after reset, no sof: offset must start at 0 (R11, R12)
    send(9, 0, 1, 4'b0101, 0);
    send(13, 1, 0, 4'b0101, 0);

    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = (pass == 1);
      for (int code = 0; code < 16; code++) begin
        for (int al = 0; al < 4; al++) begin
          for (int p = 0; p < 3; p++) begin
            logic [3:0] be;
            be = (p == 0) ? 4'hF : 4'((code * 5 + al * 3 + p) % 16);
            send(code, al[1], al[0], be, (p == 0) && (al[0] == 1'b1));
          end
        end
      end
    end

    // mixed byte counts walking the offset around the group (R11)
    stall_mode = 1'b0;
    for (int i = 0; i < 12; i++) begin
      int seq[4] = '{8, 7, 9, 14};
      send(seq[i % 4], 1, 1, 4'b0010, i == 6);
    end

    // steady back-to-back stream with irregular stalls (R1, R2)
    stall_mode = 1'b1;
    for (int i = 0; i < 40; i++) send(i % 16, i[0], i[1], 4'hF, 0);

    stall_mode = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R1 drained", 32'(q.size()), 0);
    done = 1;
    report();
  end

endmodule